// File: doc/BRIEF.md
# Aging-Tag Recency Tracker for Page Frame Replacement

This block keeps an approximate record of how recently each of N page frames was used, so that a replacement engine can choose a frame to evict. Every frame has one reference flag and a K-bit age tag. A reference strobe names a frame and raises its flag. A periodic age strobe shifts every tag one place toward the least significant end and moves each frame's flag into the top bit of its tag. The age strobe then clears all flags. A frame that is used often keeps ones near the top of its tag. A frame that has sat idle drifts toward zero.

When the controller wants a frame to replace, it raises a victim request. On the next cycle the block returns the index of the frame with the smallest tag, together with that tag value. Filling a frame with a new page goes through a load strobe. The load zeroes the frame's tag and raises its flag, so the new page counts as used in the current interval. The source of the age strobe and the handling of the victim belong to the surrounding logic.

Top module: `aging_lru_tracker`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, every tag and every reference flag is zero, vic_vld is 0, and vic_idx and vic_tag are 0.
- R2: On a cycle with tick high, each frame not being loaded takes the new tag {flag, old_tag[K-1:1]}. The flag goes into bit K-1 and the old bit 0 is dropped.
- R3: After a tick, every reference flag is 0, except in the cases that R4 and R7 name. A second tick with no reference in between therefore puts a 0 into bit K-1.
- R4: A reference that arrives in the same cycle as a tick does not enter the tag being formed. It leaves the frame's flag at 1 for the next interval.
- R5: The victim is the frame whose tag is numerically smallest, and vic_tag carries that smallest tag.
- R6: When several frames share the smallest tag, the one with the lowest index is returned.
- R7: A load (load_vld=1, load_idx=i) sets frame i's tag to 0 and its flag to 1. For that frame the load overrides a tick and a reference in the same cycle.
- R8: vic_req high in cycle t makes vic_vld high in cycle t+1, with vic_idx and vic_tag computed from the tags as they stood in cycle t. Without a request, vic_vld is 0 and vic_idx and vic_tag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_vld | input | 1 | Reference strobe |
| ref_idx | input | IW=$clog2(N) | Frame that was referenced |
| tick | input | 1 | Aging strobe |
| load_vld | input | 1 | Page-load strobe |
| load_idx | input | IW | Frame being loaded |
| vic_req | input | 1 | Victim request |
| vic_vld | output | 1 | Victim result valid, one cycle after the request |
| vic_idx | output | IW | Index of the frame with the smallest tag |
| vic_tag | output | K | Tag of the returned victim |

## Verification
The hardest case to reach is a tie for the smallest tag that appears only after flags and ticks have been combined over several intervals. It is hardest when a load or a reference lands in the same cycle as a tick. Lowest-index priority and the override rules then decide the result together. The stimulus table builds this case step by step. It references frames singly and loads one frame during a tick, which leaves several frames on equal tags. A request is placed at each point where such a tie exists. Directed runs then cover a tag draining to zero over K idle ticks and back-to-back requests.

// File: rtl/aging_pkg.sv
package aging_pkg;
   // Outcome of one comparison stage: smallest tag seen so far and its frame.
   function automatic logic pick_right(input logic [63:0] left_tag,
                                       input logic [63:0] right_tag);
      // Right wins only when strictly smaller; equal values keep the lower index.
      return right_tag < left_tag;
   endfunction
endpackage

// File: rtl/age_slot.sv
module age_slot #(
   parameter int K = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  logic         tick,
   input  logic         load,
   output logic [K-1:0] tag,
   output logic         flag
);
   if (K < 2) begin : g_bad_k
      $error("age_slot: K must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag  <= '0;
         flag <= 1'b0;
      end else if (load) begin
         tag  <= '0;
         flag <= 1'b1;
      end else begin
         if (tick) tag <= {flag, tag[K-1:1]};
         flag <= hit | (flag & ~tick);
      end
   end

   a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load) |=> (tag[K-1] == $past(flag)) && (tag[K-2:0] == $past(tag[K-1:1])));
   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hit && !load) |=> !flag);
   a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hit) |=> flag);
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tag == '0) && flag);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(tag));
endmodule

// File: rtl/age_min_search.sv
module age_min_search #(
   parameter int N    = 8,
   parameter int K    = 8,
   parameter bit TREE = 1'b1,
   localparam int IW  = (N > 1) ? $clog2(N) : 1,
   localparam int LV  = IW,
   localparam int P   = 1 << LV
) (
   input  logic                 chk_en,
   input  logic [N-1:0][K-1:0]  tags,
   output logic [IW-1:0]        min_idx,
   output logic [K-1:0]         min_tag
);
   import aging_pkg::*;

   if (K > 64) begin : g_bad_k
      $error("age_min_search: K above 64 not supported");
   end

   if (TREE) begin : g_tree
      for (genvar l = 0; l <= LV; l++) begin : g_lvl
         localparam int W = P >> l;
         logic [K-1:0]  tg [W];
         logic [IW-1:0] ix [W];
         for (genvar j = 0; j < W; j++) begin : g_node
            if (l == 0) begin : g_leaf
               if (j < N) begin : g_real
                  assign tg[j] = tags[j];
                  assign ix[j] = IW'(j);
               end else begin : g_pad
                  assign tg[j] = '1;
                  assign ix[j] = '0;
               end
            end else begin : g_cmp
               logic rt;
               assign rt = pick_right(64'(g_lvl[l-1].tg[2*j]), 64'(g_lvl[l-1].tg[2*j+1]));
               assign tg[j] = rt ? g_lvl[l-1].tg[2*j+1] : g_lvl[l-1].tg[2*j];
               assign ix[j] = rt ? g_lvl[l-1].ix[2*j+1] : g_lvl[l-1].ix[2*j];
            end
         end
      end
      assign min_tag = g_lvl[LV].tg[0];
      assign min_idx = g_lvl[LV].ix[0];
   end else begin : g_chain
      always_comb begin
         min_tag = tags[0];
         min_idx = '0;
         for (int i = 1; i < N; i++) begin
            if (pick_right(64'(min_tag), 64'(tags[i]))) begin
               min_tag = tags[i];
               min_idx = IW'(i);
            end
         end
      end
   end

   always_comb begin
      if (chk_en) begin
         for (int i = 0; i < N; i++) begin
            a_r5_min: assert (min_tag <= tags[i]);
            if (IW'(i) < min_idx) begin
               a_r6_tie: assert (tags[i] != min_tag);
            end
         end
      end
   end
endmodule

// File: rtl/age_vic_reg.sv
module age_vic_reg #(
   parameter int IW = 3,
   parameter int K  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [IW-1:0] cand_idx,
   input  logic [K-1:0]  cand_tag,
   output logic          vld,
   output logic [IW-1:0] idx,
   output logic [K-1:0]  tag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         idx <= '0;
         tag <= '0;
      end else begin
         vld <= req;
         if (req) begin
            idx <= cand_idx;
            tag <= cand_tag;
         end
      end
   end

   a_r8_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> vld && (idx == $past(cand_idx)) && (tag == $past(cand_tag)));
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !vld && $stable(idx) && $stable(tag));
   a_r1_reset: assert property (@(posedge clk)
      !rst_n |=> !vld && (idx == '0) && (tag == '0));
endmodule

// File: rtl/aging_lru_tracker.sv
module aging_lru_tracker #(
   parameter int N    = 8,
   parameter int K    = 8,
   parameter bit TREE = 1'b1,
   localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ref_vld,
   input  logic [IW-1:0] ref_idx,
   input  logic          tick,
   input  logic          load_vld,
   input  logic [IW-1:0] load_idx,
   input  logic          vic_req,
   output logic          vic_vld,
   output logic [IW-1:0] vic_idx,
   output logic [K-1:0]  vic_tag
);
   if (N < 2) begin : g_bad_n
      $error("aging_lru_tracker: N must be at least 2");
   end

   logic [N-1:0][K-1:0] tags;
   logic [N-1:0]        flags;
   logic [IW-1:0]       cand_idx;
   logic [K-1:0]        cand_tag;

   for (genvar i = 0; i < N; i++) begin : g_frame
      logic hit_i, load_i;
      assign hit_i  = ref_vld  && (ref_idx  == IW'(i));
      assign load_i = load_vld && (load_idx == IW'(i));
      age_slot #(.K(K)) slot_i (
         .clk  (clk),
         .rst_n(rst_n),
         .hit  (hit_i),
         .tick (tick),
         .load (load_i),
         .tag  (tags[i]),
         .flag (flags[i])
      );
   end

   age_min_search #(.N(N), .K(K), .TREE(TREE)) search_i (
      .chk_en (rst_n),
      .tags   (tags),
      .min_idx(cand_idx),
      .min_tag(cand_tag)
   );

   age_vic_reg #(.IW(IW), .K(K)) vic_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (vic_req),
      .cand_idx(cand_idx),
      .cand_tag(cand_tag),
      .vld     (vic_vld),
      .idx     (vic_idx),
      .tag     (vic_tag)
   );

   a_r1_clean: assert property (@(posedge clk)
      !rst_n |=> (flags == '0) && (tags == '0));
endmodule

// File: tb/aging_lru_tracker_tb.sv
module aging_lru_tracker_tb_top;
   localparam int N  = 8;
   localparam int K  = 8;
   localparam int IW = 3;
   localparam int RW = 21;
   localparam int NROWS = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_vld = 1'b0;
   logic [IW-1:0] ref_idx = '0;
   logic          tick = 1'b0;
   logic          load_vld = 1'b0;
   logic [IW-1:0] load_idx = '0;
   logic          vic_req = 1'b0;
   logic          vic_vld;
   logic [IW-1:0] vic_idx;
   logic [K-1:0]  vic_tag;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   aging_lru_tracker #(.N(N), .K(K)) dut_i (
      .clk(clk), .rst_n(rst_n), .ref_vld(ref_vld), .ref_idx(ref_idx),
      .tick(tick), .load_vld(load_vld), .load_idx(load_idx),
      .vic_req(vic_req), .vic_vld(vic_vld), .vic_idx(vic_idx), .vic_tag(vic_tag)
   );

   // Row layout: ref_vld, ref_idx, tick, load_vld, load_idx, req, exp_idx, exp_tag
   function automatic logic [RW-1:0] mk(input bit rv, input int ri, input bit tk,
                                        input bit lv, input int li, input bit rq,
                                        input int ei, input int et);
      return {rv, 3'(ri), tk, lv, 3'(li), rq, 3'(ei), 8'(et)};
   endfunction

   localparam logic [RW-1:0] VEC [NROWS] = '{
      mk(1,3,0,0,0,0,0,0),     // ref 3
      mk(1,5,0,0,0,0,0,0),     // ref 5
      mk(0,0,1,0,0,0,0,0),     // tick
      mk(0,0,0,0,0,1,0,8'h00), // R5/R6: frames 0,1,2,4,6,7 at zero
      mk(1,1,0,1,0,0,0,0),     // load 0, ref 1
      mk(1,2,1,0,0,0,0,0),     // ref 2 with tick (R4)
      mk(0,0,0,0,0,1,2,8'h00), // R4: frame 2 still zero
      mk(0,0,1,0,0,0,0,0),     // tick: frame 2 gets its carried flag
      mk(0,0,0,0,0,1,4,8'h00), // R4/R6
      mk(1,4,0,0,0,0,0,0),
      mk(1,6,0,0,0,0,0,0),
      mk(1,7,0,0,0,0,0,0),
      mk(0,0,1,0,0,0,0,0),
      mk(0,0,0,0,0,1,3,8'h10), // R2/R6: tie 3 and 5
      mk(0,0,1,0,0,0,0,0),
      mk(0,0,1,1,3,0,0,0),     // load 3 with tick (R7)
      mk(0,0,0,0,0,1,3,8'h00), // R7
      mk(0,0,1,0,0,0,0,0),
      mk(0,0,0,0,0,1,5,8'h02), // R2/R5
      mk(0,0,0,0,0,0,5,8'h02)  // R8: idle holds
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input bit rv, input int ri, input bit tk,
                        input bit lv, input int li, input bit rq);
      ref_vld = rv; ref_idx = IW'(ri); tick = tk;
      load_vld = lv; load_idx = IW'(li); vic_req = rq;
      @(negedge clk);
      ref_vld = 0; tick = 0; load_vld = 0; vic_req = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 vld", 32'(vic_vld), 0);
      check("R1 idx", 32'(vic_idx), 0);
      check("R1 tag", 32'(vic_tag), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1: after reset every tag is zero, victim is frame 0
      drive(0,0,0,0,0,1);
      check("R1 post-reset vld", 32'(vic_vld), 1);
      check("R1 post-reset idx", 32'(vic_idx), 0);
      check("R1 post-reset tag", 32'(vic_tag), 0);

      // Table walk
      for (int r = 0; r < NROWS; r++) begin
         logic [RW-1:0] v;
         v = VEC[r];
         drive(v[20], int'(v[19:17]), v[16], v[15], int'(v[14:12]), v[11]);
         if (v[11]) begin
            check($sformatf("R8 row%0d vld", r), 32'(vic_vld), 1);
            check($sformatf("R5 row%0d idx", r), 32'(vic_idx), 32'(v[10:8]));
            check($sformatf("R5 row%0d tag", r), 32'(vic_tag), 32'(v[7:0]));
         end else begin
            check($sformatf("R8 row%0d idle", r), 32'(vic_vld), 0);
         end
      end
      check("R8 held idx", 32'(vic_idx), 5);
      check("R8 held tag", 32'(vic_tag), 8'h02);

      // Mid-run reset clears everything (R1)
      do_reset();

      // R3: reference all frames, then two ticks: tags 0x40, not 0xC0
      for (int f = 0; f < N; f++) drive(1,f,0,0,0,0);
      drive(0,0,1,0,0,0);
      drive(0,0,1,0,0,0);
      drive(0,0,0,0,0,1);
      check("R3 cleared flag idx", 32'(vic_idx), 0);
      check("R3 cleared flag tag", 32'(vic_tag), 8'h40);

      // R2: bit walks to LSB, then drops out
      for (int t = 0; t < 6; t++) drive(0,0,1,0,0,0);
      drive(0,0,0,0,0,1);
      check("R2 lsb tag", 32'(vic_tag), 8'h01);
      drive(0,0,1,0,0,0);
      drive(0,0,0,0,0,1);
      check("R2 drained tag", 32'(vic_tag), 8'h00);
      check("R6 drained idx", 32'(vic_idx), 0);

      // R8: back-to-back requests, frame 0 referenced in between
      drive(1,0,0,0,0,0);
      drive(0,0,1,0,0,1);
      check("R8 b2b first vld", 32'(vic_vld), 1);
      check("R8 b2b first idx", 32'(vic_idx), 0);
      drive(0,0,0,0,0,1);
      check("R8 b2b second vld", 32'(vic_vld), 1);
      check("R8 b2b second idx", 32'(vic_idx), 1);
      check("R8 b2b second tag", 32'(vic_tag), 0);
      drive(0,0,0,0,0,0);
      check("R8 drop vld", 32'(vic_vld), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule